// File: doc/BRIEF.md
# Oscillator Stabilization Wait Timer

This block keeps a fast oscillator clock away from the rest of the chip until the oscillator has settled. A register-clock control port holds an oscillator enable bit and a 4-bit wait-length code. The block drives the oscillator's run enable. When the oscillator starts after a system reset, or after a wake from sleep, and the fast clock is the chosen system source, the block counts a programmed number of oscillator cycles. Only after that count does it open a glitch-free clock gate and raise a ready flag.

If software starts the oscillator by setting the enable bit, no hardware count runs. The gate opens as soon as the run request crosses into the oscillator domain, and software is expected to provide its own delay. Counting happens on the oscillator clock. The ready flag is returned to the register clock through a two-flop synchronizer.

Top module: `osc_stab_timer`

## Requirements
- R1: While `rst` is high, `osc_run`, `gate_en` and `ready` are 0. The enable bit resets to 1 and the wait code resets to 0xF, so `osc_run` is 1 in the first cycle after `rst` falls.
- R2: A wait with code c lasts 2^(22 − c) oscillator cycles. Code 0xF gives 128 cycles, and each lower code doubles the count, down to 4,194,304 cycles for code 0x0.
- R3: After reset with `hs_selected` high, the gate opens only once the 128-cycle default wait has completed.
- R4: `sleep_req` high forces `osc_run` low on the next `clk` edge, whatever the enable bit holds.
- R5: A wake from sleep, with the enable bit set and `hs_selected` high, runs a complete wait of the programmed length before `gate_en` rises.
- R6: Starting the oscillator by writing enable 0 and then enable 1 runs no wait. `gate_en` rises within a few oscillator cycles.
- R7: A start while `hs_selected` is low runs no wait.
- R8: Sleep during a wait cancels it and keeps `gate_en` and `ready` low. The next wake runs a full new wait.
- R9: The wait code is captured when a wait begins. A write during the wait does not change that wait's length.
- R10: `gate_en` changes only while `osc_clk` is low. `gated_clk` follows `osc_clk` while `gate_en` is 1 and is 0 otherwise.
- R11: `ready` is `gate_en` passed through two `clk` flops. It is low after sleep has been held for a few cycles.
- R12: A write (`wr_en` high) loads `wr_osc_en` and `wr_wait_sel` together. `osc_run` is registered as the new enable value ANDed with not `sleep_req`, so clearing the enable stops the oscillator on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-interface clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe |
| wr_osc_en | input | 1 | Oscillator enable value to write |
| wr_wait_sel | input | 4 | Wait-length code to write |
| sleep_req | input | 1 | Sleep mode request |
| hs_selected | input | 1 | Fast oscillator or PLL is the system source |
| osc_clk | input | 1 | Oscillator clock |
| osc_run | output | 1 | Oscillator run enable |
| gate_en | output | 1 | Clock-gate enable (oscillator domain) |
| gated_clk | output | 1 | Gated oscillator clock |
| ready | output | 1 | Clock ready flag (`clk` domain) |

## Verification
Corruption of the counter, of the captured length or of the start-cause flag shows at the ports as a wrong gap between `osc_run` rising and `gate_en` rising. That gap is measured in oscillator cycles for every start, to within the synchronizer slack. A start-cause flag that is wrongly set or cleared turns a wait into an immediate open, or the reverse, within a few cycles of the start. A state machine stuck in the counting or open state is exposed within about eight register cycles of sleep, when `ready` or `gate_en` fails to drop.

// File: rtl/osw_pkg.sv
package osw_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } osc_state_e;

  localparam int DEF_SEL_W   = 4;
  localparam int DEF_MAX_EXP = 22;
endpackage

// File: rtl/osw_sync.sv
module osw_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/osw_ctrl.sv
module osw_ctrl #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_osc_en,
  input  logic [SEL_W-1:0] wr_wait_sel,
  input  logic             sleep_req,
  input  logic             hs_selected,
  output logic             osc_run,
  output logic             hw_wait,
  output logic [SEL_W-1:0] wait_sel
);
  localparam logic [SEL_W-1:0] SEL_RESET = '1;

  logic en_q;
  logic en_d;
  logic cause_q;
  logic cause_d;

  assign en_d = wr_en ? wr_osc_en : en_q;

  // start-cause flag: hardware wait pending unless software stopped the oscillator
  always_comb begin
    cause_d = cause_q;
    if (wr_en && !wr_osc_en)    cause_d = 1'b0;
    else if (sleep_req && en_d) cause_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b1;
      wait_sel <= SEL_RESET;
      cause_q  <= 1'b1;
      osc_run  <= 1'b0;
      hw_wait  <= 1'b0;
    end else begin
      en_q     <= en_d;
      if (wr_en) wait_sel <= wr_wait_sel;
      cause_q  <= cause_d;
      osc_run  <= en_d & ~sleep_req;
      hw_wait  <= cause_d & hs_selected;
    end
  end
endmodule

// File: rtl/osw_counter.sv
module osw_counter
  import osw_pkg::*;
#(
  parameter int SEL_W   = 4,
  parameter int MAX_EXP = 22
) (
  input  logic             osc_clk,
  input  logic             rst_o,
  input  logic             run_s,
  input  logic             wait_s,
  input  logic [SEL_W-1:0] wait_sel,
  output logic             open_req
);
  localparam int CNT_W = MAX_EXP + 1;

  osc_state_e       st;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] shamt;
  logic [CNT_W-1:0] len_m1;

  assign shamt  = CNT_W'(MAX_EXP) - CNT_W'(wait_sel);
  assign len_m1 = (CNT_W'(1) << shamt) - CNT_W'(1);

  always_ff @(posedge osc_clk) begin
    if (rst_o) begin
      st       <= ST_OFF;
      cnt      <= '0;
      last_idx <= '0;
    end else begin
      case (st)
        ST_OFF: begin
          if (run_s) begin
            if (wait_s) begin
              st       <= ST_WAIT;
              cnt      <= '0;
              last_idx <= len_m1;
            end else begin
              st <= ST_RUN;
            end
          end
        end
        ST_WAIT: begin
          if (!run_s)               st  <= ST_OFF;
          else if (cnt == last_idx) st  <= ST_RUN;
          else                      cnt <= cnt + CNT_W'(1);
        end
        ST_RUN: begin
          if (!run_s) st <= ST_OFF;
        end
        default: st <= ST_OFF;
      endcase
    end
  end

  assign open_req = (st == ST_RUN);
endmodule

// File: rtl/osw_gate.sv
module osw_gate (
  input  logic osc_clk,
  input  logic rst_o,
  input  logic open_req,
  output logic gate_en,
  output logic gated_clk
);
  // updated on the falling edge so the enable moves only in the low phase
  always_ff @(negedge osc_clk) begin
    if (rst_o) gate_en <= 1'b0;
    else       gate_en <= open_req;
  end

  assign gated_clk = osc_clk & gate_en;
endmodule

// File: rtl/osc_stab_timer.sv
module osc_stab_timer
  import osw_pkg::*;
#(
  parameter int SEL_W       = DEF_SEL_W,
  parameter int MAX_EXP     = DEF_MAX_EXP,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_osc_en,
  input  logic [SEL_W-1:0] wr_wait_sel,
  input  logic             sleep_req,
  input  logic             hs_selected,
  input  logic             osc_clk,
  output logic             osc_run,
  output logic             gate_en,
  output logic             gated_clk,
  output logic             ready
);
  logic             hw_wait;
  logic [SEL_W-1:0] wait_sel;
  logic             rst_o;
  logic [1:0]       req_s;
  logic             open_req;

  osw_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .wr_osc_en   (wr_osc_en),
    .wr_wait_sel (wr_wait_sel),
    .sleep_req   (sleep_req),
    .hs_selected (hs_selected),
    .osc_run     (osc_run),
    .hw_wait     (hw_wait),
    .wait_sel    (wait_sel)
  );

  osw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk (osc_clk),
    .rst (1'b0),
    .d   (rst),
    .q   (rst_o)
  );

  osw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk (osc_clk),
    .rst (rst_o),
    .d   ({osc_run, hw_wait}),
    .q   (req_s)
  );

  osw_counter #(.SEL_W(SEL_W), .MAX_EXP(MAX_EXP)) u_cnt (
    .osc_clk  (osc_clk),
    .rst_o    (rst_o),
    .run_s    (req_s[1]),
    .wait_s   (req_s[0]),
    .wait_sel (wait_sel),
    .open_req (open_req)
  );

  osw_gate u_gate (
    .osc_clk   (osc_clk),
    .rst_o     (rst_o),
    .open_req  (open_req),
    .gate_en   (gate_en),
    .gated_clk (gated_clk)
  );

  osw_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_rdy_sync (
    .clk (clk),
    .rst (rst),
    .d   (gate_en),
    .q   (ready)
  );
endmodule

// File: rtl/osc_stab_timer_chk.sv
module osc_stab_timer_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic wr_osc_en,
  input logic sleep_req,
  input logic osc_clk,
  input logic osc_run,
  input logic gate_en,
  input logic ready
);
  logic [3:0] slp_cnt;

  always_ff @(posedge clk) begin
    if (rst || !sleep_req)  slp_cnt <= '0;
    else if (slp_cnt != 4'd15) slp_cnt <= slp_cnt + 4'd1;
  end

  a_r1_reset_outputs_low: assert property (@(posedge clk)
    rst |=> (!osc_run && !ready));

  a_r4_sleep_stops_osc: assert property (@(posedge clk) disable iff (rst)
    sleep_req |=> !osc_run);

  a_r12_enable_write_runs: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_osc_en && !sleep_req) |=> osc_run);

  a_r11_long_sleep_not_ready: assert property (@(posedge clk) disable iff (rst)
    (slp_cnt == 4'd15) |-> (!ready && !gate_en));

  always @(posedge gate_en or negedge gate_en) begin
    a_r10_gate_changes_low: assert (osc_clk == 1'b0);
  end
endmodule

bind osc_stab_timer osc_stab_timer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_osc_en (wr_osc_en),
  .sleep_req (sleep_req),
  .osc_clk   (osc_clk),
  .osc_run   (osc_run),
  .gate_en   (gate_en),
  .ready     (ready)
);

// File: tb/tb_osc_stab_timer.sv
`timescale 1ns/100ps
module tb_osc_stab_timer;
  logic       clk = 1'b0;
  logic       osc_clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_osc_en = 1'b0;
  logic [3:0] wr_wait_sel = 4'h0;
  logic       sleep_req = 1'b0;
  logic       hs_selected = 1'b1;
  logic       osc_run, gate_en, gated_clk, ready;

  int checks = 0;
  int errors = 0;
  int gcnt = 0;

  typedef struct {
    bit    waits;
    int    code;
    string tag;
  } exp_t;
  exp_t sbq[$];

  always #4   clk = ~clk;
  always #3.5 osc_clk = ~osc_clk;

  osc_stab_timer dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_osc_en(wr_osc_en),
    .wr_wait_sel(wr_wait_sel), .sleep_req(sleep_req), .hs_selected(hs_selected),
    .osc_clk(osc_clk), .osc_run(osc_run), .gate_en(gate_en),
    .gated_clk(gated_clk), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic push_exp(input bit waits, input int code, input string tag);
    exp_t e;
    e.waits = waits; e.code = code; e.tag = tag;
    sbq.push_back(e);
  endtask

  // monitor: oscillator cycles from run request to gate opening
  bit armed = 1'b0;
  int meas = 0;
  always @(posedge osc_clk) begin
    if (rst) begin
      armed = 1'b1; meas = 0;
    end else if (!osc_run) begin
      armed = 1'b1; meas = 0;
    end else if (armed && !gate_en) begin
      meas++;
    end else if (armed && gate_en) begin
      armed = 1'b0;
      if (sbq.size() == 0) begin
        chk(1'b0, "R2", "unexpected gate opening", meas, 0);
      end else begin
        exp_t e;
        int   len;
        e = sbq.pop_front();
        if (e.waits) begin
          len = 1 << (22 - e.code);
          chk(meas >= len + 2 && meas <= len + 4, e.tag, "wait length", meas, len + 3);
        end else begin
          chk(meas <= 6, e.tag, "no-wait start cycles", meas, 3);
        end
      end
    end
  end

  always @(posedge gated_clk) gcnt++;

  task automatic ctl_write(input bit en, input logic [3:0] sel);
    @(negedge clk);
    wr_en = 1'b1; wr_osc_en = en; wr_wait_sel = sel;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enter_sleep(input string req);
    @(negedge clk);
    sleep_req = 1'b1;
    @(negedge clk);
    chk(osc_run == 1'b0, req, "osc_run in sleep", osc_run, 0);
    repeat (30) @(negedge clk);
    chk(ready == 1'b0, "R11", "ready in sleep", ready, 0);
    chk(gate_en == 1'b0, req, "gate_en in sleep", gate_en, 0);
  endtask

  task automatic wake;
    @(negedge clk);
    sleep_req = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!ready && n < 90000) begin
      @(negedge clk);
      n++;
    end
    chk(ready == 1'b1, req, "ready reached", ready, 1);
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int g0;
    // R1 reset state
    push_exp(1'b1, 15, "R3");
    repeat (10) @(negedge clk);
    chk(osc_run == 1'b0, "R1", "osc_run in reset", osc_run, 0);
    chk(gate_en == 1'b0, "R1", "gate_en in reset", gate_en, 0);
    chk(ready == 1'b0, "R1", "ready in reset", ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(osc_run == 1'b1, "R1", "osc_run after reset", osc_run, 1);
    wait_ready("R3");

    // R5 wake with code 0xD
    ctl_write(1'b1, 4'hD);
    enter_sleep("R4");
    push_exp(1'b1, 13, "R5");
    wake();
    wait_ready("R5");

    // R2 code 0xA
    ctl_write(1'b1, 4'hA);
    enter_sleep("R4");
    push_exp(1'b1, 10, "R2");
    wake();
    wait_ready("R2");

    // R12 software stop, R6 software start without wait
    ctl_write(1'b0, 4'hA);
    chk(osc_run == 1'b0, "R12", "osc_run after disable", osc_run, 0);
    repeat (30) @(negedge clk);
    chk(ready == 1'b0, "R12", "ready after disable", ready, 0);
    push_exp(1'b0, 0, "R6");
    ctl_write(1'b1, 4'hA);
    wait_ready("R6");

    // R7 fast source not selected
    hs_selected = 1'b0;
    enter_sleep("R4");
    push_exp(1'b0, 0, "R7");
    wake();
    wait_ready("R7");
    hs_selected = 1'b1;

    // R8 sleep in the middle of a wait
    ctl_write(1'b1, 4'h9);
    enter_sleep("R4");
    wake();
    repeat (1000) @(negedge clk);
    chk(ready == 1'b0, "R8", "ready mid-wait", ready, 0);
    chk(gate_en == 1'b0, "R8", "gate_en mid-wait", gate_en, 0);
    enter_sleep("R8");
    push_exp(1'b1, 9, "R8");
    wake();
    wait_ready("R8");

    // R9 write during wait does not change its length
    ctl_write(1'b1, 4'hD);
    enter_sleep("R4");
    push_exp(1'b1, 13, "R9");
    wake();
    repeat (40) @(negedge clk);
    ctl_write(1'b1, 4'h6);
    wait_ready("R9");

    // R2 long code 0x6 (new code applies to next wait)
    enter_sleep("R4");
    push_exp(1'b1, 6, "R2");
    wake();
    wait_ready("R2");

    // R10 gated clock runs while open
    g0 = gcnt;
    repeat (50) @(negedge clk);
    chk((gcnt - g0) >= 50 && (gcnt - g0) <= 60, "R10", "gated edges while open", gcnt - g0, 57);

    // R4 sleep while disabled; R12 wake keeps oscillator off
    ctl_write(1'b0, 4'h6);
    enter_sleep("R4");
    g0 = gcnt;
    repeat (20) @(negedge clk);
    chk(gcnt == g0, "R10", "gated edges while closed", gcnt - g0, 0);
    wake();
    repeat (30) @(negedge clk);
    chk(osc_run == 1'b0, "R12", "osc_run after wake while disabled", osc_run, 0);
    chk(ready == 1'b0, "R12", "ready after wake while disabled", ready, 0);
    push_exp(1'b0, 0, "R6");
    ctl_write(1'b1, 4'h6);
    wait_ready("R6");

    chk(sbq.size() == 0, "R2", "pending expectations", sbq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule